// File: doc/BRIEF.md
# Transmit Byte Queue with Frame Replay

This block is the byte-wide transmit queue that sits between a host slave write port and an Ethernet transmitter. The host loads bytes through one of two paths: a register-style access that decodes a five-bit address, or a dedicated direct strobe that needs no address. The host marks the last byte of each frame with an end-of-frame flag. The queue then hands the bytes to the transmitter over a valid/ready stream, and each byte carries that flag.

The queue remembers where the current frame starts. When a collision forces a resend, a retry pulse rewinds the read position to that start point. When the frame is finished, a commit pulse moves the start point forward. A start-permission output tells the transmitter when enough of the frame is buffered. A data-request output asks the host for more bytes once enough space is free.

Free space is counted from the frame start at first. Once the frame has progressed past the point where a resend is still possible, it is counted from the live read position instead.

The read stream follows these rules. `rd_valid` is high only while start is permitted and an unread byte is present. A byte is consumed on a rising clock edge where `rd_valid` and `rd_ready` are both high. `rd_data` and `rd_eof` hold steady while `rd_ready` is low. The host side has no back-pressure: a write that arrives when the queue is full is dropped.

Top module: `tx_retry_fifo`

## Requirements
- R1: A register-style write is taken when `host_sel`=1, `host_strobe`=0, `host_rw`=0 (0 means write) and `host_addr`=5'b00001. Any other address, or `host_rw`=1, writes nothing.
- R2: A direct write is taken when `host_strobe`=1, `host_sel`=0 and `host_rw`=0, whatever `host_addr` holds. With `host_rw`=1 nothing is written.
- R3: When `host_sel` and `host_strobe` are both 1 in the same cycle, no byte is written.
- R4: Holding the strobe active over N consecutive clock edges writes N bytes, and they are read back in write order.
- R5: The queue holds 128 bytes. A write that arrives while it is full is dropped and sets `ovf`. `ovf` then stays 1 until reset.
- R6: `tx_go` rises once the bytes of the current frame (counted from the saved frame start) reach the start threshold. The threshold is 64 after reset and is reloaded from `cfg_start_thr` when `cfg_we`=1.
- R7: `tx_go` is 1 regardless of the threshold while a byte written with `host_eof`=1 has not yet been committed, or while the queue is full.
- R8: `rd_valid` is 1 when `tx_go`=1 and unread data is present. A handshake advances the read position by one byte. `rd_eof` is 1 on the byte that was written with `host_eof`.
- R9: `data_req` is 1 when the free bytes are at least the watermark. The watermark is chosen by `cfg_wm_sel` (loaded with `cfg_we`): code 0 selects 16, code 1 selects 32, and codes 2 and 3 select 64. Code 0 applies after reset. Free bytes are 128 minus the bytes held from the saved frame start.
- R10: Once 56 data bytes of the frame have been read (64 line bytes counting the 8 preamble bytes), free space and fullness are counted from the live read position instead of the saved start.
- R11: `tx_retry` rewinds the read position to the saved frame start on the next edge. It takes priority over a read handshake and over `tx_frame_done` in the same cycle, and a host write in that same cycle is still accepted.
- R12: `tx_frame_done` (without `tx_retry`) moves the saved frame start to the read position and retires one pending end-of-frame mark.
- R13: Reset clears all pointers, pending marks and `ovf`, and restores the default threshold and watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Register-style chip select, active high |
| host_strobe | input | 1 | Direct queue strobe, active high |
| host_rw | input | 1 | 1 read, 0 write |
| host_addr | input | 5 | Register address |
| host_wdata | input | 8 | Write byte |
| host_eof | input | 1 | Marks the last byte of a frame |
| cfg_we | input | 1 | Load threshold and watermark select |
| cfg_start_thr | input | 8 | Start threshold in bytes |
| cfg_wm_sel | input | 2 | Watermark code |
| tx_retry | input | 1 | Rewind to frame start (pulse) |
| tx_frame_done | input | 1 | Commit current frame (pulse) |
| rd_valid | output | 1 | Byte available to transmitter |
| rd_ready | input | 1 | Transmitter accepts byte |
| rd_data | output | 8 | Byte to transmitter |
| rd_eof | output | 1 | Byte is last of its frame |
| tx_go | output | 1 | Transmission may begin |
| data_req | output | 1 | Host should supply more data |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Two events can land in the same cycle: a host write and a retry rewind. They touch different pointers, so both must take effect. The bench provokes this by reading one byte and then raising `tx_retry` together with a direct write. It then checks that the rewound stream returns the first byte again, followed by the older bytes and then the byte written during the rewind, in order. A second collision case raises retry and commit in the same cycle. There the bench checks that the stream restarts at the old frame start, which shows the retry prevailed.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       eof;
  } txf_entry_t;

  function automatic int unsigned wm_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 32'd16;
      2'd1:    return 32'd32;
      default: return 32'd64;
    endcase
  endfunction

endpackage

// File: rtl/txf_host_decode.sv
module txf_host_decode #(
  parameter int          ADDR_W    = 5,
  parameter logic [4:0]  FIFO_ADDR = 5'd1
) (
  input  logic              host_sel,
  input  logic              host_strobe,
  input  logic              host_rw,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              wr_req
);
  logic reg_path;
  logic dir_path;

  always_comb begin
    reg_path = host_sel && !host_strobe && (host_addr == ADDR_W'(FIFO_ADDR));
    dir_path = host_strobe && !host_sel;
    wr_req   = !host_rw && (reg_path || dir_path);
  end
endmodule

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  txf_pkg::txf_entry_t  wentry,
  input  logic [AW-1:0]        raddr,
  output txf_pkg::txf_entry_t  rentry
);
  txf_pkg::txf_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign rentry = mem[raddr];
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int DEPTH      = 128,
  parameter int PW         = $clog2(DEPTH) + 1,
  parameter int LIVE_BYTES = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          wr_eof,
  input  logic          rd_ready,
  input  logic          retry,
  input  logic          done,
  input  logic [PW-1:0] start_thr,
  input  logic [1:0]    wm_code,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] saved_ptr,
  output logic          wr_en,
  output logic          rd_valid,
  output logic          tx_go,
  output logic          data_req,
  output logic          ovf
);
  logic [PW-1:0] used_saved, used_rd, sent, used_base, free_bytes, eof_cnt;
  logic          live, full, pop, commit, eof_inc, eof_dec;

  always_comb begin
    used_saved = wr_ptr - saved_ptr;
    used_rd    = wr_ptr - rd_ptr;
    sent       = rd_ptr - saved_ptr;
    live       = sent >= PW'(LIVE_BYTES);
    used_base  = live ? used_rd : used_saved;
    full       = used_base == PW'(DEPTH);
    free_bytes = PW'(DEPTH) - used_base;
    data_req   = 32'(free_bytes) >= txf_pkg::wm_bytes(wm_code);
    wr_en      = wr_req && !full;
    tx_go      = (eof_cnt != '0) || full || (used_saved >= start_thr);
    rd_valid   = tx_go && (rd_ptr != wr_ptr);
    pop        = rd_valid && rd_ready && !retry;
    commit     = done && !retry;
    eof_inc    = wr_en && wr_eof;
    eof_dec    = commit && (eof_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      saved_ptr <= '0;
      eof_cnt   <= '0;
      ovf       <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (retry)    rd_ptr <= saved_ptr;
      else if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (commit) saved_ptr <= rd_ptr;
      if (eof_inc && !eof_dec)      eof_cnt <= eof_cnt + 1'b1;
      else if (eof_dec && !eof_inc) eof_cnt <= eof_cnt - 1'b1;
      if (wr_req && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_retry_fifo.sv
module tx_retry_fifo #(
  parameter int         DEPTH      = 128,
  parameter int         ADDR_W     = 5,
  parameter logic [4:0] FIFO_ADDR  = 5'd1,
  parameter int         START_RST  = 64,
  parameter int         LIVE_BYTES = 56,
  parameter int         THR_W      = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_strobe,
  input  logic              host_rw,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_eof,
  input  logic              cfg_we,
  input  logic [THR_W-1:0]  cfg_start_thr,
  input  logic [1:0]        cfg_wm_sel,
  input  logic              tx_retry,
  input  logic              tx_frame_done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              rd_eof,
  output logic              tx_go,
  output logic              data_req,
  output logic              ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]       wr_ptr, rd_ptr, saved_ptr;
  logic [THR_W-1:0]    thr_q;
  logic [1:0]          wm_q;
  logic                wr_req, wr_en;
  txf_pkg::txf_entry_t wentry, rentry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= THR_W'(START_RST);
      wm_q  <= 2'd0;
    end else if (cfg_we) begin
      thr_q <= cfg_start_thr;
      wm_q  <= cfg_wm_sel;
    end
  end

  txf_host_decode #(.ADDR_W(ADDR_W), .FIFO_ADDR(FIFO_ADDR)) u_dec (
    .host_sel(host_sel), .host_strobe(host_strobe), .host_rw(host_rw),
    .host_addr(host_addr), .wr_req(wr_req)
  );

  assign wentry = '{data: host_wdata, eof: host_eof};

  txf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_ptr[AW-1:0]), .wentry(wentry),
    .raddr(rd_ptr[AW-1:0]), .rentry(rentry)
  );

  txf_ctrl #(.DEPTH(DEPTH), .PW(PW), .LIVE_BYTES(LIVE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_eof(host_eof),
    .rd_ready(rd_ready), .retry(tx_retry), .done(tx_frame_done),
    .start_thr(PW'(thr_q)), .wm_code(wm_q), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .saved_ptr(saved_ptr), .wr_en(wr_en), .rd_valid(rd_valid), .tx_go(tx_go),
    .data_req(data_req), .ovf(ovf)
  );

  assign rd_data = rentry.data;
  assign rd_eof  = rentry.eof;
endmodule

// File: rtl/tx_retry_fifo_chk.sv
module tx_retry_fifo_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_strobe,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          tx_retry,
  input logic          tx_frame_done,
  input logic          ovf,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] saved_ptr
);
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_strobe) |=> wr_ptr == $past(wr_ptr)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R5
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !tx_retry) |=> rd_ptr == PW'($past(rd_ptr) + 1'b1)); // R8
  AST_RETRY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry |=> rd_ptr == $past(saved_ptr)); // R11
  AST_COMMIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame_done && !tx_retry) |=> saved_ptr == $past(rd_ptr)); // R12
  AST_RETRY_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry |=> $stable(saved_ptr)); // R11
endmodule

bind tx_retry_fifo tx_retry_fifo_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_strobe(host_strobe),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .tx_retry(tx_retry),
  .tx_frame_done(tx_frame_done), .ovf(ovf), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .saved_ptr(saved_ptr)
);

// File: tb/tx_retry_fifo_bench.sv
module tx_retry_fifo_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  // vector: {sel, strobe, rw, addr[4:0], expect_accept}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 5'b00001, 1'b1},  // R1 register path
    {1'b1, 1'b0, 1'b0, 5'b00010, 1'b0},  // R1 wrong address
    {1'b0, 1'b1, 1'b0, 5'b10110, 1'b1},  // R2 direct, address ignored
    {1'b0, 1'b1, 1'b1, 5'b00001, 1'b0},  // R2 direct read
    {1'b1, 1'b0, 1'b1, 5'b00001, 1'b0},  // R1 register read
    {1'b1, 1'b1, 1'b0, 5'b00001, 1'b0},  // R3 both active
    {1'b0, 1'b0, 1'b0, 5'b00001, 1'b0}   // nothing active
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 0, host_strobe = 0, host_rw = 0, host_eof = 0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic cfg_we = 0;
  logic [7:0] cfg_start_thr = '0;
  logic [1:0] cfg_wm_sel = '0;
  logic tx_retry = 0, tx_frame_done = 0, rd_ready = 0;
  logic rd_valid, rd_eof, tx_go, data_req, ovf;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_retry_fifo u_tx_retry_fifo (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_strobe(host_strobe),
    .host_rw(host_rw), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_eof(host_eof), .cfg_we(cfg_we), .cfg_start_thr(cfg_start_thr),
    .cfg_wm_sel(cfg_wm_sel), .tx_retry(tx_retry), .tx_frame_done(tx_frame_done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_eof(rd_eof),
    .tx_go(tx_go), .data_req(data_req), .ovf(ovf)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_wr(input logic s, input logic f, input logic rw,
                         input logic [4:0] a, input logic [7:0] d, input logic e);
    host_sel = s; host_strobe = f; host_rw = rw; host_addr = a;
    host_wdata = d; host_eof = e;
    @(negedge clk);
    host_sel = 0; host_strobe = 0; host_rw = 0; host_eof = 0;
  endtask

  task automatic burst(input int n, input int base);
    host_strobe = 1'b1; host_addr = 5'b11111;
    for (int i = 0; i < n; i++) begin
      host_wdata = 8'(base + i);
      @(negedge clk);
    end
    host_strobe = 1'b0;
  endtask

  task automatic pop(input int exp_d, input int exp_e, input string tag);
    chk(rd_valid, 1, tag);
    chk(rd_data, exp_d, tag);
    chk(rd_eof, exp_e, tag);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic set_cfg(input int thr, input int wm);
    cfg_we = 1'b1; cfg_start_thr = 8'(thr); cfg_wm_sel = 2'(wm);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(rd_valid, 0, "R13 reset rd_valid");
    chk(tx_go, 0, "R13 reset tx_go");
    chk(ovf, 0, "R13 reset ovf");
    chk(data_req, 1, "R13 reset data_req");

    // decode table, R1 R2 R3
    set_cfg(1, 0);
    for (int i = 0; i < NVEC; i++) begin
      host_wr(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:1], 8'(8'hA0 + i), 1'b0);
      chk(rd_valid, int'(VEC[i][0]), $sformatf("R1_R2_R3 vector %0d valid", i));
      if (VEC[i][0]) pop(8'hA0 + i, 0, $sformatf("R1_R2 vector %0d data", i));
    end

    // threshold, watermark, live mode, retry
    do_reset();
    burst(63, 0);
    chk(tx_go, 0, "R6 below default threshold");
    burst(1, 63);
    chk(tx_go, 1, "R6 default threshold 64 reached");
    chk(data_req, 1, "R9 free 64 vs 16");
    set_cfg(64, 2);
    chk(data_req, 1, "R9 free 64 vs 64");
    burst(1, 64);
    chk(data_req, 0, "R9 free 63 vs 64");
    set_cfg(64, 1);
    chk(data_req, 1, "R9 free 63 vs 32");
    set_cfg(64, 3);
    chk(data_req, 0, "R9 code 3 is 64");
    for (int i = 0; i < 55; i++) pop(i, 0, "R4 burst order");
    chk(data_req, 0, "R10 still counted from frame start");
    pop(55, 0, "R4 burst order");
    chk(data_req, 1, "R10 live pointer after 56 bytes");
    tx_retry = 1'b1; @(negedge clk); tx_retry = 1'b0;
    chk(rd_data, 0, "R11 retry replays first byte");
    chk(data_req, 0, "R11 retry returns to frame start count");

    // end of frame, commit
    do_reset();
    host_wr(0, 1, 0, 5'd0, 8'h11, 0);
    host_wr(0, 1, 0, 5'd0, 8'h22, 0);
    chk(tx_go, 0, "R7 no eof yet");
    host_wr(0, 1, 0, 5'd0, 8'h33, 1);
    chk(tx_go, 1, "R7 complete frame starts");
    pop(8'h11, 0, "R8 byte 1");
    pop(8'h22, 0, "R8 byte 2");
    pop(8'h33, 1, "R8 last byte eof");
    chk(rd_valid, 0, "R8 drained");
    tx_frame_done = 1'b1; @(negedge clk); tx_frame_done = 1'b0;
    chk(tx_go, 0, "R12 commit retires eof");
    tx_retry = 1'b1; @(negedge clk); tx_retry = 1'b0;
    chk(rd_valid, 0, "R12 start moved, retry replays nothing");

    // full and overflow
    do_reset();
    set_cfg(200, 0);
    burst(127, 0);
    chk(tx_go, 0, "R7 127 bytes below threshold");
    burst(1, 127);
    chk(tx_go, 1, "R7 full starts");
    chk(ovf, 0, "R5 no overflow at exactly full");
    chk(data_req, 0, "R9 no free space");
    burst(1, 8'hEE);
    chk(ovf, 1, "R5 overflow on write when full");
    pop(0, 0, "R5 dropped write left data intact");
    chk(ovf, 1, "R5 ovf sticky");
    do_reset();
    chk(ovf, 0, "R13 reset clears ovf");

    // write and retry in the same cycle
    set_cfg(1, 0);
    host_wr(0, 1, 0, 5'd0, 8'h41, 0);
    host_wr(0, 1, 0, 5'd0, 8'h42, 0);
    pop(8'h41, 0, "R11 first read");
    tx_retry = 1'b1; host_strobe = 1'b1; host_wdata = 8'h43;
    @(negedge clk);
    tx_retry = 1'b0; host_strobe = 1'b0;
    pop(8'h41, 0, "R11 replay with concurrent write");
    pop(8'h42, 0, "R11 replay second");
    pop(8'h43, 0, "R11 concurrent write kept");
    chk(rd_valid, 0, "R11 drained");
    tx_retry = 1'b1; tx_frame_done = 1'b1; @(negedge clk);
    tx_retry = 1'b0; tx_frame_done = 1'b0;
    chk(rd_data, 8'h41, "R11 retry beats commit");
    chk(rd_valid, 1, "R11 retry beats commit valid");

    finished = 1;
    summary();
    $finish;
  end
endmodule